// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block sits beside a small 8-bit processor core. It collects interrupt events from twelve sources and decides which of them the core should service, and when. Each source has a pending flag. A peripheral can set the flag with a one-cycle pulse, or software can write it. A request is formed only when the flag, the source's own enable and a global enable are all set. Each source belongs to one of two priority levels.

The core reports every instruction end with a boundary strobe. With that strobe it says whether the finishing instruction took a single cycle, and whether it was a return from a handler. The controller accepts a request only at such a boundary. It then pulses an acknowledge, presents the handler address and pushes the level onto a two-deep in-service record. If the source is configured for it, the pending flag clears at the same time.

Writing the global enable to zero is not seen by arbitration at once: if the very next instruction is single-cycle, a request may still be taken at its end. A flag that is still set after a return fires again only after one more instruction has completed.

Top module: `mcu_irq_ctrl`

## Requirements
- R1: After reset all pending flags are 0, the global enable reads 0, and irq_o and ack_o are 0.
- R2: A pulse on hw_set_i[k] sets pending flag k on the next cycle, whatever the state of src_en_i and of the global enable.
- R3: A write on pend_wr_i loads all flags from pend_wdata_i, so a 1 sets a flag and a 0 clears it. A hardware set in the same cycle wins over a written 0.
- R4: irq_o is 1 only when some flag is set whose src_en_i bit is 1 while the global enable is 1. With the global enable at 0 and no leak window open (R10), irq_o is 0.
- R5: A request is accepted only in a cycle with bnd_i high. ack_o is high in the next cycle, and vec_o then holds 0x0003 + 8*k for the accepted source k.
- R6: When several requests compete, a source with src_hi_i=1 beats every source with src_hi_i=0. Within the same level the lowest index wins.
- R7: When source k is accepted, its flag clears if auto_clr_i[k]=1 and stays set if auto_clr_i[k]=0.
- R8: While a low-level handler runs, only high-level requests are accepted. While a high-level handler runs, nothing is accepted. Up to two handlers can be nested.
- R9: No request is accepted at a boundary where reti_i is high; that boundary ends the current handler. A flag still pending is then accepted at the next boundary.
- R10: ea_o drops in the cycle after a write of 0 on ea_wr_i. If the next instruction ends with bnd_single_i=1, a pending enabled request is still accepted at that boundary. If that instruction is multi-cycle, the request is not accepted.
- R11: A flag set by a software write is accepted and vectored exactly like one set by hardware.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hw_set_i | input | 12 | Per-source hardware event pulses |
| pend_wr_i | input | 1 | Software write strobe for the pending flags |
| pend_wdata_i | input | 12 | Value written to the pending flags |
| src_en_i | input | 12 | Per-source enables |
| src_hi_i | input | 12 | Per-source level, 1 = high |
| auto_clr_i | input | 12 | Per-source auto-clear on acceptance |
| ea_wr_i | input | 1 | Global enable write strobe |
| ea_wdata_i | input | 1 | Global enable write value |
| bnd_i | input | 1 | Last cycle of an instruction |
| bnd_single_i | input | 1 | The finishing instruction is single-cycle |
| reti_i | input | 1 | The finishing instruction is a return from a handler |
| irq_o | output | 1 | Request that is admissible now |
| ack_o | output | 1 | One-cycle acceptance pulse |
| vec_o | output | 16 | Handler address of the last accepted source |
| pend_o | output | 12 | Pending flags |
| ea_o | output | 1 | Global enable as read by software |

## Verification
Some rules are checked by assertions on every cycle. Acceptance happens only after a boundary with a live request and never on a return boundary. The vector always lands on the 8-byte grid. A hardware pulse always leaves its flag set. A cleared global enable outside a single-cycle boundary masks everything. Two nested handlers block any further request. Other behaviour can only be shown by the bench's directed instruction sequences: which source wins under mixed levels and indices, the one-instruction delay before a still-pending flag re-fires, the different outcomes of a global disable followed by single-cycle and by multi-cycle instructions, and auto-clear against kept flags.

// File: rtl/irq_pkg.sv
`timescale 1ns/1ps
package irq_pkg;
  typedef enum logic {LVL_LO = 1'b0, LVL_HI = 1'b1} lvl_e;
endpackage

// File: rtl/irq_flags.sv
`timescale 1ns/1ps
module irq_flags #(
  parameter int N_SRC = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] hw_set_i,
  input  logic             wr_i,
  input  logic [N_SRC-1:0] wdata_i,
  input  logic [N_SRC-1:0] clr_i,
  output logic [N_SRC-1:0] pend_o
);
  logic [N_SRC-1:0] pend_q, base;

  // hardware set wins over both software clear and auto-clear
  always_comb begin
    base = wr_i ? wdata_i : pend_q;
    base = base & ~clr_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= base | hw_set_i;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_pick.sv
`timescale 1ns/1ps
module irq_pick #(
  parameter int N_SRC = 12,
  parameter int IDX_W = 4
) (
  input  logic [N_SRC-1:0] req_i,
  output logic             hit_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        hit_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_nest.sv
`timescale 1ns/1ps
module irq_nest
  import irq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bnd_i,
  input  logic       bnd_single_i,
  input  logic       reti_i,
  input  logic       ea_wr_i,
  input  logic       ea_wdata_i,
  input  logic       take_i,
  input  logic       take_hi_i,
  output logic       ea_o,
  output logic       ea_arb_o,
  output logic       allow_lo_o,
  output logic       allow_hi_o,
  output logic [1:0] depth_o
);
  logic       ea_q, hold_q;
  logic [1:0] depth_q;
  lvl_e       lvl0_q;
  logic       top_hi;

  // a clear of the global enable stays invisible to a single-cycle successor
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ea_q   <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      if (ea_wr_i) ea_q <= ea_wdata_i;
      if (ea_wr_i && !ea_wdata_i && ea_q) hold_q <= 1'b1;
      else if (bnd_i || (ea_wr_i && ea_wdata_i)) hold_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      depth_q <= 2'd0;
      lvl0_q  <= LVL_LO;
    end else if (take_i) begin
      if (depth_q == 2'd0) lvl0_q <= lvl_e'(take_hi_i);
      depth_q <= depth_q + 2'd1;
    end else if (bnd_i && reti_i && depth_q != 2'd0) begin
      depth_q <= depth_q - 2'd1;
    end
  end

  assign top_hi     = (depth_q == 2'd2) || (depth_q == 2'd1 && lvl0_q == LVL_HI);
  assign allow_hi_o = !top_hi;
  assign allow_lo_o = (depth_q == 2'd0);
  assign ea_o       = ea_q;
  assign ea_arb_o   = ea_q | (hold_q & bnd_single_i);
  assign depth_o    = depth_q;
endmodule

// File: rtl/mcu_irq_ctrl.sv
`timescale 1ns/1ps
module mcu_irq_ctrl #(
  parameter int N_SRC    = 12,
  parameter int VEC_W    = 16,
  parameter int VEC_BASE = 3,
  parameter int VEC_STEP = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] hw_set_i,
  input  logic             pend_wr_i,
  input  logic [N_SRC-1:0] pend_wdata_i,
  input  logic [N_SRC-1:0] src_en_i,
  input  logic [N_SRC-1:0] src_hi_i,
  input  logic [N_SRC-1:0] auto_clr_i,
  input  logic             ea_wr_i,
  input  logic             ea_wdata_i,
  input  logic             bnd_i,
  input  logic             bnd_single_i,
  input  logic             reti_i,
  output logic             irq_o,
  output logic             ack_o,
  output logic [VEC_W-1:0] vec_o,
  output logic [N_SRC-1:0] pend_o,
  output logic             ea_o
);
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;
  localparam logic [VEC_W-1:0] BASE_V = VEC_W'(VEC_BASE);
  localparam logic [VEC_W-1:0] STEP_V = VEC_W'(VEC_STEP);

  logic [N_SRC-1:0] pend, cand, clr_vec;
  logic             ea_arb, allow_lo, allow_hi;
  logic [1:0]       nest_depth;
  logic [1:0]       lvl_hit;
  logic [IDX_W-1:0] lvl_idx [2];
  logic             sel_hi, sel_lo, take;
  logic [IDX_W-1:0] sel_idx;
  logic             ack_q;
  logic [VEC_W-1:0] vec_q;

  irq_flags #(.N_SRC(N_SRC)) u_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hw_set_i(hw_set_i),
    .wr_i    (pend_wr_i),
    .wdata_i (pend_wdata_i),
    .clr_i   (clr_vec),
    .pend_o  (pend)
  );

  assign cand = pend & src_en_i & {N_SRC{ea_arb}};

  for (genvar l = 0; l < 2; l++) begin : g_lvl
    logic [N_SRC-1:0] lvl_req;
    assign lvl_req = cand & ((l == 1) ? src_hi_i : ~src_hi_i);
    irq_pick #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_pick (
      .req_i(lvl_req),
      .hit_o(lvl_hit[l]),
      .idx_o(lvl_idx[l])
    );
  end

  irq_nest u_nest (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bnd_i       (bnd_i),
    .bnd_single_i(bnd_single_i),
    .reti_i      (reti_i),
    .ea_wr_i     (ea_wr_i),
    .ea_wdata_i  (ea_wdata_i),
    .take_i      (take),
    .take_hi_i   (sel_hi),
    .ea_o        (ea_o),
    .ea_arb_o    (ea_arb),
    .allow_lo_o  (allow_lo),
    .allow_hi_o  (allow_hi),
    .depth_o     (nest_depth)
  );

  assign sel_hi  = lvl_hit[1] & allow_hi;
  assign sel_lo  = !sel_hi & lvl_hit[0] & allow_lo;
  assign sel_idx = sel_hi ? lvl_idx[1] : lvl_idx[0];
  assign irq_o   = sel_hi | sel_lo;
  assign take    = irq_o & bnd_i & !reti_i;

  always_comb begin
    clr_vec = '0;
    if (take) clr_vec[sel_idx] = auto_clr_i[sel_idx];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q <= 1'b0;
      vec_q <= '0;
    end else begin
      ack_q <= take;
      if (take) vec_q <= BASE_V + STEP_V * VEC_W'(sel_idx);
    end
  end

  assign ack_o  = ack_q;
  assign vec_o  = vec_q;
  assign pend_o = pend;
endmodule

// File: rtl/irq_ctrl_chk.sv
`timescale 1ns/1ps
module irq_ctrl_chk #(
  parameter int N_SRC    = 12,
  parameter int VEC_W    = 16,
  parameter int VEC_BASE = 3,
  parameter int VEC_STEP = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             bnd_i,
  input logic             bnd_single_i,
  input logic             reti_i,
  input logic [N_SRC-1:0] hw_set_i,
  input logic             irq_o,
  input logic             ack_o,
  input logic [VEC_W-1:0] vec_o,
  input logic [N_SRC-1:0] pend_o,
  input logic             ea_o,
  input logic [1:0]       depth_i
);
  localparam int VEC_TOP = VEC_BASE + VEC_STEP * (N_SRC - 1);

  a_r5_ack_at_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> ($past(bnd_i) && $past(irq_o)));

  a_r9_no_take_on_reti: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bnd_i && reti_i) |=> !ack_o);

  a_r4_ea_masks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ea_o && !bnd_single_i) |-> !irq_o);

  a_r2_set_latches: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend_o & $past(hw_set_i)) == $past(hw_set_i)));

  a_r8_hi_not_preempted: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (depth_i == 2'd2) |-> !irq_o);

  a_r5_vec_grid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> (int'(vec_o) >= VEC_BASE && int'(vec_o) <= VEC_TOP &&
               ((int'(vec_o) - VEC_BASE) % VEC_STEP) == 0));
endmodule

bind mcu_irq_ctrl irq_ctrl_chk #(
  .N_SRC(N_SRC), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bnd_i       (bnd_i),
  .bnd_single_i(bnd_single_i),
  .reti_i      (reti_i),
  .hw_set_i    (hw_set_i),
  .irq_o       (irq_o),
  .ack_o       (ack_o),
  .vec_o       (vec_o),
  .pend_o      (pend_o),
  .ea_o        (ea_o),
  .depth_i     (nest_depth)
);

// File: tb/tb_mcu_irq_ctrl.sv
`timescale 1ns/1ps
module tb_mcu_irq_ctrl;
  localparam int N = 12;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [N-1:0]  hw_set_i = '0, pend_wdata_i = '0;
  logic [N-1:0]  src_en_i = '0, src_hi_i = '0, auto_clr_i = '0;
  logic          pend_wr_i = 0, ea_wr_i = 0, ea_wdata_i = 0;
  logic          bnd_i = 0, bnd_single_i = 0, reti_i = 0;
  logic          irq_o, ack_o, ea_o;
  logic [15:0]   vec_o;
  logic [N-1:0]  pend_o;

  int n_chk = 0, n_err = 0;
  bit acked;
  logic [15:0] vec;

  mcu_irq_ctrl dut (.*);

  always #4 clk_i = ~clk_i;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] vec_for(input int k);
    return 16'(3 + 8 * k);
  endfunction

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 0; hw_set_i = '0; pend_wr_i = 0; pend_wdata_i = '0;
    src_en_i = '0; src_hi_i = '0; auto_clr_i = '0;
    ea_wr_i = 0; ea_wdata_i = 0; bnd_i = 0; bnd_single_i = 0; reti_i = 0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
  endtask

  task automatic pulse(input logic [N-1:0] m);
    @(negedge clk_i); hw_set_i = m;
    @(negedge clk_i); hw_set_i = '0;
  endtask

  task automatic wr_pend(input logic [N-1:0] d, input logic [N-1:0] hw);
    @(negedge clk_i); pend_wr_i = 1; pend_wdata_i = d; hw_set_i = hw;
    @(negedge clk_i); pend_wr_i = 0; hw_set_i = '0;
  endtask

  task automatic set_ea(input logic v);
    @(negedge clk_i); ea_wr_i = 1; ea_wdata_i = v;
    @(negedge clk_i); ea_wr_i = 0;
  endtask

  // one instruction of len cycles; boundary strobe in its last cycle
  task automatic instr(input int len, input bit ret, input bit clr_ea,
                       output bit ak, output logic [15:0] v);
    for (int i = 0; i < len; i++) begin
      @(negedge clk_i);
      if (i == len - 1) begin
        bnd_i = 1; bnd_single_i = (len == 1); reti_i = ret;
        if (clr_ea) begin ea_wr_i = 1; ea_wdata_i = 0; end
      end
    end
    @(negedge clk_i);
    ak = ack_o; v = vec_o;
    bnd_i = 0; bnd_single_i = 0; reti_i = 0; ea_wr_i = 0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 pend", 32'(pend_o), 0);
    chk("R1 ea", 32'(ea_o), 0);
    chk("R1 irq", 32'(irq_o), 0);
    chk("R1 ack", 32'(ack_o), 0);
  endtask

  task automatic t_latch();
    do_reset();
    pulse(12'h020);
    chk("R2 latch while disabled", 32'(pend_o), 32'h020);
    chk("R4 no irq disabled", 32'(irq_o), 0);
    @(negedge clk_i); src_en_i = 12'h020;
    @(negedge clk_i);
    chk("R4 global off masks", 32'(irq_o), 0);
    set_ea(1);
    chk("R4 irq when all enabled", 32'(irq_o), 1);
  endtask

  task automatic t_sw();
    do_reset();
    wr_pend(12'h0A0, '0);
    chk("R3 write ones", 32'(pend_o), 32'h0A0);
    wr_pend(12'h000, 12'h080);
    chk("R3 hw set beats write 0", 32'(pend_o), 32'h080);
  endtask

  task automatic t_boundary();
    do_reset();
    src_en_i = '1; auto_clr_i = '1;
    set_ea(1);
    pulse(12'h008);
    repeat (3) @(negedge clk_i);
    chk("R5 irq pending", 32'(irq_o), 1);
    chk("R5 no ack off boundary", 32'(ack_o), 0);
    instr(3, 0, 0, acked, vec);
    chk("R5 ack at boundary", 32'(acked), 1);
    chk("R5 vector src3", 32'(vec), 32'(vec_for(3)));
    chk("R7 auto clear", 32'(pend_o[3]), 0);
  endtask

  task automatic t_prio();
    do_reset();
    src_en_i = '1; auto_clr_i = '1; src_hi_i = 12'h200;
    set_ea(1);
    wr_pend(12'h214, '0);
    instr(1, 0, 0, acked, vec);
    chk("R6 high level first", 32'(vec), 32'(vec_for(9)));
    instr(1, 0, 0, acked, vec);
    chk("R8 high not preempted", 32'(acked), 0);
    instr(1, 1, 0, acked, vec);
    chk("R9 none on return", 32'(acked), 0);
    instr(1, 0, 0, acked, vec);
    chk("R6 lowest index ack", 32'(acked), 1);
    chk("R6 lowest index vec", 32'(vec), 32'(vec_for(2)));
    instr(2, 0, 0, acked, vec);
    chk("R8 low not preempted by low", 32'(acked), 0);
    instr(1, 1, 0, acked, vec);
    instr(1, 0, 0, acked, vec);
    chk("R9 next low after return", 32'(vec), 32'(vec_for(4)));
  endtask

  task automatic t_preempt();
    do_reset();
    src_en_i = '1; auto_clr_i = '1; src_hi_i = 12'h040;
    set_ea(1);
    pulse(12'h002);
    instr(1, 0, 0, acked, vec);
    chk("R8 low taken", 32'(vec), 32'(vec_for(1)));
    pulse(12'h040);
    instr(2, 0, 0, acked, vec);
    chk("R8 high preempts low ack", 32'(acked), 1);
    chk("R8 high preempts low vec", 32'(vec), 32'(vec_for(6)));
  endtask

  task automatic t_noauto();
    do_reset();
    src_en_i = '1; auto_clr_i = ~12'h001;
    set_ea(1);
    wr_pend(12'h001, '0);
    instr(1, 0, 0, acked, vec);
    chk("R11 sw flag vectors", 32'(vec), 32'(vec_for(0)));
    chk("R7 flag kept", 32'(pend_o[0]), 1);
    instr(2, 0, 0, acked, vec);
    chk("R8 no self preempt", 32'(acked), 0);
    instr(1, 1, 0, acked, vec);
    chk("R9 blocked at return", 32'(acked), 0);
    instr(1, 0, 0, acked, vec);
    chk("R9 refire after one instr", 32'(acked), 1);
  endtask

  task automatic t_leak(input int next_len);
    do_reset();
    src_en_i = 12'h400; auto_clr_i = '1;
    set_ea(1);
    instr(2, 0, 1, acked, vec);
    chk("R10 ea cleared", 32'(ea_o), 0);
    pulse(12'h400);
    instr(next_len, 0, 0, acked, vec);
    if (next_len == 1) begin
      chk("R10 single-cycle leak", 32'(acked), 1);
      chk("R10 leak vector", 32'(vec), 32'(vec_for(10)));
      chk("R10 ea reads 0 in handler", 32'(ea_o), 0);
    end else begin
      chk("R10 multi-cycle blocks", 32'(acked), 0);
      instr(1, 0, 0, acked, vec);
      chk("R10 window closed", 32'(acked), 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_latch();
    t_sw();
    t_boundary();
    t_prio();
    t_preempt();
    t_noauto();
    t_leak(1);
    t_leak(2);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule